// File: doc/BRIEF.md
# Trigger-Stepped Waveform Overlay for a Converter Channel

This block sits in front of one converter channel's output register. On each accepted trigger it takes the channel's 12-bit holding value and adds a generated waveform sample to it. The waveform is either pseudo-random noise from a linear feedback shift register (LFSR) or a triangle that ramps up and down. The sum is registered as the 12-bit output. With the overlay turned off, a trigger copies the holding value unchanged.

A 4-bit amplitude field sets how wide the waveform is. In noise mode it sets how many low LFSR bits are added. In triangle mode it sets the peak. The waveform and amplitude fields can be written only while the channel is disabled. Once the channel is enabled they are locked.

When triggering is not enabled, the holding value passes straight to the output every cycle and the waveform does not move. When the channel itself is disabled, the output register keeps its value.

Top module: `wave_overlay_gen`

## Requirements
- R1: After synchronous reset the output is 0, the mode readback is 00 (off) and the amplitude readback is 0.
- R2: Mode code 00 is off. An accepted trigger (channel enabled, triggering enabled, trigger high at a clock edge) loads the holding value unchanged into the output on that edge.
- R3: Mode code 01 is noise. A 12-bit LFSR has reset seed 0xACE. Its next state is {s[10:0], s[11]^s[5]^s[3]^s[0]}. An accepted trigger loads hold + (s AND m) into the output, then steps the LFSR once. Mask m has its low n+1 bits set for amplitude value n, and n above 11 gives m = 0xFFF.
- R4: Mode codes 10 and 11 are triangle. A counter starts at 0 and climbs by one per trigger to the peak P = 2^(k)−1 with k = min(n+1, 12). It then falls by one per trigger to 0 and repeats. An accepted trigger loads hold + counter and then steps the counter.
- R5: The sum of the holding value and the waveform sample wraps modulo 4096.
- R6: A configuration write (cfg_we high at an edge) updates mode and amplitude only while chan_en is low. An accepted write returns the LFSR to its seed and the triangle to 0, counting up. While chan_en is high, writes have no effect on the readback or the output sequence.
- R7: With chan_en high and trig_en low, the output takes the holding value on every edge, and trigger pulses do not advance the waveform.
- R8: With chan_en low, the output register keeps its value and trigger pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; also locks the configuration |
| trig_en | input | 1 | Trigger mode enable |
| trig | input | 1 | Trigger pulse, one step per high cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Waveform code: 00 off, 01 noise, 1x triangle |
| cfg_amp | input | 4 | Mask/amplitude value n |
| hold_val | input | 12 | Holding value |
| out_val | output | 12 | Registered output value |
| mode_rb | output | 2 | Current waveform code |
| amp_rb | output | 4 | Current amplitude value |

## Verification
Most of this block's state is hidden: the LFSR contents, the triangle count and its direction only reach the port as an offset added to the holding value. A wrong tap, seed or turn-around point therefore shows at out_val on the very trigger where that state is used, one edge after the trigger. A generator that steps when it should not shows only at the next accepted trigger. That is why the bypass and lock tests always follow their stimulus with a normal trigger. A configuration write that gets past the lock shows at once on the readback ports.

// File: rtl/wog_pkg.sv
package wog_pkg;
  typedef enum logic [1:0] {
    WV_OFF     = 2'b00,
    WV_NOISE   = 2'b01,
    WV_TRI     = 2'b10,
    WV_TRI_ALT = 2'b11
  } wave_mode_e;

  function automatic logic is_tri(input wave_mode_e m);
    return (m == WV_TRI) || (m == WV_TRI_ALT);
  endfunction
endpackage

// File: rtl/wog_cfg.sv
module wog_cfg
  import wog_pkg::*;
#(
  parameter int AMP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             we,
  input  logic [1:0]       mode_in,
  input  logic [AMP_W-1:0] amp_in,
  output wave_mode_e       mode_q,
  output logic [AMP_W-1:0] amp_q,
  output logic             init_o
);
  assign init_o = we && !chan_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= WV_OFF;
      amp_q  <= '0;
    end else if (init_o) begin
      mode_q <= wave_mode_e'(mode_in);
      amp_q  <= amp_in;
    end
  end

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> ($stable(mode_q) && $stable(amp_q)));
endmodule

// File: rtl/wog_lfsr.sv
module wog_lfsr #(
  parameter int           W    = 12,
  parameter logic [W-1:0] TAPS = 12'h829,
  parameter logic [W-1:0] SEED = 12'hACE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst || init) state <= SEED;
    else if (step)   state <= {state[W-2:0], fb};
  end

  p_lfsr_live_r3: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  p_lfsr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !init) |=> $stable(state));
endmodule

// File: rtl/wog_tri.sv
module wog_tri #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  input  logic [W-1:0] peak,
  output logic [W-1:0] cnt
);
  logic rising;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (step) begin
      if (rising) begin
        if (cnt >= peak) begin
          rising <= 1'b0;
          cnt    <= cnt - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          rising <= 1'b1;
          cnt    <= cnt + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  p_tri_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= peak);
  p_tri_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !init) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));
endmodule

// File: rtl/wave_overlay_gen.sv
module wave_overlay_gen
  import wog_pkg::*;
#(
  parameter int              DATA_W    = 12,
  parameter int              AMP_W     = 4,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 12'h829,
  parameter logic [DATA_W-1:0] LFSR_SEED = 12'hACE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              trig_en,
  input  logic              trig,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [AMP_W-1:0]  cfg_amp,
  input  logic [DATA_W-1:0] hold_val,
  output logic [DATA_W-1:0] out_val,
  output logic [1:0]        mode_rb,
  output logic [AMP_W-1:0]  amp_rb
);
  wave_mode_e        mode_q;
  logic [AMP_W-1:0]  amp_q;
  logic              gen_init;
  logic              accept;
  logic [DATA_W-1:0] amp_mask;
  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] tri_q;
  logic [DATA_W-1:0] wave_sample;

  wog_cfg #(.AMP_W(AMP_W)) cfg_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .we(cfg_we),
    .mode_in(cfg_mode), .amp_in(cfg_amp),
    .mode_q(mode_q), .amp_q(amp_q), .init_o(gen_init)
  );

  // Mask bit i set when i <= n; values beyond the width fill every bit.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign amp_mask[i] = (32'(amp_q) >= i);
  end

  assign accept = chan_en && trig_en && trig;

  wog_lfsr #(.W(DATA_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
    .clk(clk), .rst(rst), .init(gen_init),
    .step(accept && (mode_q == WV_NOISE)), .state(lfsr_q)
  );

  wog_tri #(.W(DATA_W)) tri_i (
    .clk(clk), .rst(rst), .init(gen_init),
    .step(accept && is_tri(mode_q)), .peak(amp_mask), .cnt(tri_q)
  );

  always_comb begin
    unique case (mode_q)
      WV_NOISE:          wave_sample = lfsr_q & amp_mask;
      WV_TRI, WV_TRI_ALT: wave_sample = tri_q;
      default:           wave_sample = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      out_val <= '0;
    else if (chan_en && !trig_en) out_val <= hold_val;
    else if (accept)              out_val <= hold_val + wave_sample;
  end

  assign mode_rb = mode_q;
  assign amp_rb  = amp_q;

  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !trig_en) |=> (out_val == $past(hold_val)));
  p_disabled_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> $stable(out_val));
  p_off_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_q == WV_OFF) |=> (out_val == $past(hold_val)));
endmodule

// File: tb/wave_overlay_gen_tb_top.sv
module wave_overlay_gen_tb_top;
  logic clk = 0;
  logic rst, chan_en, trig_en, trig, cfg_we;
  logic [1:0] cfg_mode;
  logic [3:0] cfg_amp;
  logic [11:0] hold_val, out_val;
  logic [1:0] mode_rb;
  logic [3:0] amp_rb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wave_overlay_gen dut_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en), .trig(trig),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_amp(cfg_amp),
    .hold_val(hold_val), .out_val(out_val), .mode_rb(mode_rb), .amp_rb(amp_rb)
  );

  // reference state
  logic [11:0] m_lfsr, m_tri;
  bit m_up;

  function automatic logic [11:0] lfsr_next(input logic [11:0] s);
    return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
  endfunction

  function automatic logic [11:0] mask_of(input int n);
    int k = (n + 1 > 12) ? 12 : n + 1;
    return 12'((1 << k) - 1);
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] m, input logic [3:0] a);
    @(negedge clk);
    chan_en = 0; cfg_we = 1; cfg_mode = m; cfg_amp = a;
    @(negedge clk);
    cfg_we = 0; chan_en = 1; trig_en = 1;
    m_lfsr = 12'hACE; m_tri = 0; m_up = 1;
  endtask

  task automatic pulse(input logic [11:0] h);
    @(negedge clk);
    hold_val = h; trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic tri_step(input logic [11:0] pk);
    if (m_up) begin
      if (m_tri >= pk) begin m_up = 0; m_tri = m_tri - 1; end
      else m_tri = m_tri + 1;
    end else begin
      if (m_tri == 0) begin m_up = 1; m_tri = m_tri + 1; end
      else m_tri = m_tri - 1;
    end
  endtask

  task automatic t_reset;
    check("R1", out_val, 0);
    check("R1", {10'd0, mode_rb}, 0);
    check("R1", {8'd0, amp_rb}, 0);
  endtask

  task automatic t_off;
    do_cfg(2'b00, 4'd7);
    for (int i = 0; i < 4; i++) begin
      pulse(12'(i * 301 + 5));
      check("R2", out_val, 12'(i * 301 + 5));
    end
  endtask

  task automatic t_noise(input int n);
    logic [11:0] h;
    do_cfg(2'b01, 4'(n));
    for (int i = 0; i < 10; i++) begin
      h = 12'(i * 113);
      pulse(h);
      check("R3", out_val, h + (m_lfsr & mask_of(n)));
      m_lfsr = lfsr_next(m_lfsr);
    end
  endtask

  task automatic t_tri(input logic [1:0] code, input int n, input int steps);
    logic [11:0] pk = mask_of(n);
    do_cfg(code, 4'(n));
    for (int i = 0; i < steps; i++) begin
      pulse(12'h100);
      check("R4", out_val, 12'h100 + m_tri);
      tri_step(pk);
    end
  endtask

  task automatic t_wrap;
    do_cfg(2'b10, 4'd1);
    for (int i = 0; i < 4; i++) begin
      pulse(12'hFFE);
      check("R5", out_val, 12'(12'hFFE + i));
    end
  endtask

  task automatic t_lock;
    do_cfg(2'b10, 4'd1);
    pulse(12'h010);
    check("R6", out_val, 12'h010);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 2'b01; cfg_amp = 4'd9;
    @(negedge clk);
    cfg_we = 0;
    check("R6", {10'd0, mode_rb}, 12'd2);
    check("R6", {8'd0, amp_rb}, 12'd1);
    pulse(12'h010);
    check("R6", out_val, 12'h011);
  endtask

  task automatic t_bypass;
    do_cfg(2'b10, 4'd1);
    pulse(12'h200);
    check("R7", out_val, 12'h200);
    @(negedge clk);
    trig_en = 0;
    for (int i = 0; i < 3; i++) begin
      hold_val = 12'(12'h300 + i); trig = 1;
      @(negedge clk);
      check("R7", out_val, 12'(12'h300 + i));
    end
    trig = 0; trig_en = 1;
    pulse(12'h200);
    check("R7", out_val, 12'h201);
  endtask

  task automatic t_disabled;
    logic [11:0] keep;
    do_cfg(2'b00, 4'd0);
    pulse(12'h5A5);
    keep = out_val;
    @(negedge clk);
    chan_en = 0;
    pulse(12'h123);
    check("R8", out_val, keep);
    @(negedge clk);
    hold_val = 12'h777;
    @(negedge clk);
    check("R8", out_val, keep);
    chan_en = 1;
  endtask

  initial begin
    rst = 1; chan_en = 0; trig_en = 0; trig = 0; cfg_we = 0;
    cfg_mode = 0; cfg_amp = 0; hold_val = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_off();
    t_noise(0);
    t_noise(4);
    t_noise(15);
    t_tri(2'b10, 0, 6);
    t_tri(2'b10, 2, 20);
    t_tri(2'b11, 3, 36);
    t_wrap();
    t_lock();
    t_bypass();
    t_disabled();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule